// File: doc/BRIEF.md
# Clock Divider and Low-Power Enable Controller

This block generates three clock-enable streams for a small processor subsystem: a main enable for the CPU, a sub-main enable for peripherals and an auxiliary enable for slow timers. All logic runs on one system clock, which stands for the fast oscillator. The low-frequency oscillator arrives as a single-cycle tick input that has already been brought into the system clock domain. Each enable stream is a train of one-cycle pulses. Downstream logic uses these pulses to qualify its registers instead of using gated clocks.

Two byte-wide control words are loaded through a simple write port. They choose the source oscillator for the main and sub-main streams and set a power-of-two division ratio for each of the three streams. Four low-power inputs come from the CPU status register: CPU-off, fast-oscillator-off, sub-main-off and low-frequency-oscillator-off. They stop individual streams and drive the two oscillator enable outputs. A pending interrupt or a wakeup request overrides the CPU-off and fast-oscillator-off inputs, so the CPU can leave a low-power mode.

Top module: `clk_en_ctrl`

## Requirements
- R1: While `rst` is high, all three enable outputs are 0 and both oscillator enables are 1. After reset every division ratio is /1 and both selectable streams take the fast source.
- R2: A 2-bit divider code n divides a stream by 2^n. The main code is bits 5:4 of control word 1 (`reg_addr`=1). The sub-main code is bits 2:1 of control word 1. The auxiliary code is bits 5:4 of control word 0 (`reg_addr`=0).
- R3: Bit 7 of control word 1 selects the main source and bit 3 selects the sub-main source. A value of 1 selects the low-frequency ticks. A value of 0 selects the fast source, which ticks on every cycle while `fast_osc_en` is 1. The auxiliary stream always counts low-frequency ticks.
- R4: A new division ratio takes effect only at the next pulse of the old ratio. Every gap between two pulses therefore equals either the old period or the new period.
- R5: When `cpu_off` is 1 and no wake input is active, `main_ce` is 0 from the next cycle on.
- R6: When `scg0` is 1 and no wake input is active, `fast_osc_en` drops to 0 on the next cycle. Streams that take the fast source then stop.
- R7: When `scg1` is 1, `sub_ce` is 0 from the next cycle on.
- R8: When `osc_off` is 1, `lf_osc_en` drops to 0 on the next cycle and `aux_ce` is 0 from the next cycle on. A main stream that takes the low-frequency source also stops.
- R9: While `irq_req` or `wakeup_req` is 1, `fast_osc_en` is 1 on the next cycle and the main stream runs. When the fast oscillator was off, `main_ce` pulses one cycle after `fast_osc_en` returns.
- R10: When the parameter `ENABLE_SCG0` is 0, `fast_osc_en` stays at 1 whatever `scg0` does.
- R11: The bits of the control words that hold no field are ignored. Setting them changes no division ratio and no source selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the fast oscillator |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control words |
| reg_addr | input | 1 | Control word select: 0 auxiliary word, 1 main/sub word |
| reg_wdata | input | 8 | Write data |
| lf_tick | input | 1 | One-cycle tick per low-frequency oscillator period |
| cpu_off | input | 1 | Low-power bit that stops the main stream |
| scg0 | input | 1 | Low-power bit that switches off the fast oscillator |
| scg1 | input | 1 | Low-power bit that stops the sub-main stream |
| osc_off | input | 1 | Low-power bit that switches off the low-frequency oscillator |
| irq_req | input | 1 | Unmasked interrupt pending |
| wakeup_req | input | 1 | External wakeup request |
| main_ce | output | 1 | Main (CPU) clock-enable pulse |
| sub_ce | output | 1 | Sub-main (peripheral) clock-enable pulse |
| aux_ce | output | 1 | Auxiliary clock-enable pulse |
| fast_osc_en | output | 1 | Fast oscillator enable |
| lf_osc_en | output | 1 | Low-frequency oscillator enable |

## Verification
Some properties hold on every cycle, and assertions check them continuously. Each low-power input silences its own stream on the next cycle, and each pulse traces back to a source tick while the stream was running. Wake inputs force the fast oscillator on, and a divider with a ratio above one never emits two pulses in a row. The bench checks the things a single-cycle property cannot see. It counts pulses over long windows for every combination of ratio and source, which confirms the division arithmetic. It records the gaps between pulses across a change of ratio. It also checks the two-step recovery from deep sleep, the build without fast-oscillator gating, and that unused register bits have no effect.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DIV_SEL_W = 2;
  localparam int NUM_CH    = 3;
  localparam int CH_MAIN   = 0;
  localparam int CH_SUB    = 1;
  localparam int CH_AUX    = 2;

  // field positions decoded from the control words
  localparam int W1_MAIN_SRC = 7;
  localparam int W1_MAIN_DIV = 4;
  localparam int W1_SUB_SRC  = 3;
  localparam int W1_SUB_DIV  = 1;
  localparam int W0_AUX_DIV  = 4;

  typedef struct packed {
    logic                 main_lf;
    logic [DIV_SEL_W-1:0] main_div;
    logic                 sub_lf;
    logic [DIV_SEL_W-1:0] sub_div;
    logic [DIV_SEL_W-1:0] aux_div;
  } clk_cfg_t;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output clk_cfg_t          cfg_o
);
  clk_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      if (wr_addr) begin
        cfg_q.main_lf  <= wr_data[W1_MAIN_SRC];
        cfg_q.main_div <= wr_data[W1_MAIN_DIV +: DIV_SEL_W];
        cfg_q.sub_lf   <= wr_data[W1_SUB_SRC];
        cfg_q.sub_div  <= wr_data[W1_SUB_DIV +: DIV_SEL_W];
      end else begin
        cfg_q.aux_div  <= wr_data[W0_AUX_DIV +: DIV_SEL_W];
      end
    end
  end

  // bits without a field are deliberately dropped
  logic unused_wdata;
  assign unused_wdata = ^{wr_data[6], wr_data[0], wr_data[DATA_W-1:6], wr_data[3:0]};

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q)); // R11
endmodule

// File: rtl/clkctl_lpm.sv
module clkctl_lpm #(
  parameter bit ENABLE_SCG0 = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_off_i,
  input  logic scg0_i,
  input  logic scg1_i,
  input  logic osc_off_i,
  input  logic irq_i,
  input  logic wake_i,
  output logic run_main_o,
  output logic run_sub_o,
  output logic run_aux_o,
  output logic fast_en_o,
  output logic lf_en_o
);
  logic wake_any;
  logic fast_en_d;
  logic fast_en_q;
  logic lf_en_q;

  assign wake_any   = irq_i | wake_i;
  assign run_main_o = !cpu_off_i || wake_any;
  assign run_sub_o  = !scg1_i;
  assign run_aux_o  = !osc_off_i;

  generate
    if (ENABLE_SCG0) begin : g_scg0
      assign fast_en_d = !(scg0_i && !wake_any);
      AST_FAST_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (scg0_i && !wake_any) |=> !fast_en_o); // R6
    end else begin : g_no_scg0
      assign fast_en_d = 1'b1;
      logic unused_scg0;
      assign unused_scg0 = scg0_i;
      AST_FAST_KEPT: assert property (@(posedge clk) disable iff (rst)
        scg0_i |=> fast_en_o); // R10
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_en_q <= 1'b1;
      lf_en_q   <= 1'b1;
    end else begin
      fast_en_q <= fast_en_d;
      lf_en_q   <= !osc_off_i;
    end
  end

  assign fast_en_o = fast_en_q;
  assign lf_en_o   = lf_en_q;

  AST_WAKE_FAST: assert property (@(posedge clk) disable iff (rst)
    wake_any |=> fast_en_o); // R9
  AST_LF_SLEEP: assert property (@(posedge clk) disable iff (rst)
    osc_off_i |=> !lf_en_o); // R8
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_tick_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ce_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask_q;
  logic [CNT_W-1:0] mask_d;
  logic             tick;
  logic             ce_q;

  always_comb begin
    mask_d = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(sel_i)) mask_d[b] = 1'b1;
    end
  end

  assign tick = src_tick_i && run_i;

  // the ratio is loaded only when a pulse leaves, never mid-period
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mask_q <= '0;
      ce_q   <= 1'b0;
    end else begin
      ce_q <= 1'b0;
      if (tick) begin
        if (cnt_q == mask_q) begin
          ce_q   <= 1'b1;
          cnt_q  <= '0;
          mask_q <= mask_d;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ce_o = ce_q;

  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    ce_q |-> $past(src_tick_i && run_i)); // R3
  AST_NO_SHORT_GAP: assert property (@(posedge clk) disable iff (rst)
    (ce_q && mask_q != '0) |=> !ce_q); // R4
endmodule

// File: rtl/clk_en_ctrl.sv
module clk_en_ctrl
  import clkctl_pkg::*;
#(
  parameter bit ENABLE_SCG0 = 1'b1,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              lf_tick,
  input  logic              cpu_off,
  input  logic              scg0,
  input  logic              scg1,
  input  logic              osc_off,
  input  logic              irq_req,
  input  logic              wakeup_req,
  output logic              main_ce,
  output logic              sub_ce,
  output logic              aux_ce,
  output logic              fast_osc_en,
  output logic              lf_osc_en
);
  clk_cfg_t             cfg;
  logic                 run_main, run_sub, run_aux;
  logic                 fast_en, lf_en;
  logic                 fast_src, lf_src;
  logic [NUM_CH-1:0]    ch_tick;
  logic [NUM_CH-1:0]    ch_run;
  logic [DIV_SEL_W-1:0] ch_sel [NUM_CH];
  logic [NUM_CH-1:0]    ch_ce;

  clkctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .cfg_o   (cfg)
  );

  clkctl_lpm #(.ENABLE_SCG0(ENABLE_SCG0)) u_lpm (
    .clk        (clk),
    .rst        (rst),
    .cpu_off_i  (cpu_off),
    .scg0_i     (scg0),
    .scg1_i     (scg1),
    .osc_off_i  (osc_off),
    .irq_i      (irq_req),
    .wake_i     (wakeup_req),
    .run_main_o (run_main),
    .run_sub_o  (run_sub),
    .run_aux_o  (run_aux),
    .fast_en_o  (fast_en),
    .lf_en_o    (lf_en)
  );

  assign fast_src = fast_en;
  assign lf_src   = lf_tick && lf_en;

  always_comb begin
    ch_tick[CH_MAIN] = cfg.main_lf ? lf_src : fast_src;
    ch_tick[CH_SUB]  = cfg.sub_lf  ? lf_src : fast_src;
    ch_tick[CH_AUX]  = lf_src;
    ch_run[CH_MAIN]  = run_main;
    ch_run[CH_SUB]   = run_sub;
    ch_run[CH_AUX]   = run_aux;
    ch_sel[CH_MAIN]  = cfg.main_div;
    ch_sel[CH_SUB]   = cfg.sub_div;
    ch_sel[CH_AUX]   = cfg.aux_div;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      clkctl_div #(.SEL_W(DIV_SEL_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .src_tick_i (ch_tick[g]),
        .run_i      (ch_run[g]),
        .sel_i      (ch_sel[g]),
        .ce_o       (ch_ce[g])
      );
    end
  endgenerate

  assign main_ce     = ch_ce[CH_MAIN];
  assign sub_ce      = ch_ce[CH_SUB];
  assign aux_ce      = ch_ce[CH_AUX];
  assign fast_osc_en = fast_en;
  assign lf_osc_en   = lf_en;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!main_ce && !sub_ce && !aux_ce && fast_osc_en && lf_osc_en)); // R1
  AST_MAIN_HALT: assert property (@(posedge clk) disable iff (rst)
    (cpu_off && !irq_req && !wakeup_req) |=> !main_ce); // R5
  AST_SUB_HALT: assert property (@(posedge clk) disable iff (rst)
    scg1 |=> !sub_ce); // R7
  AST_AUX_HALT: assert property (@(posedge clk) disable iff (rst)
    osc_off |=> !aux_ce); // R8
  AST_AUX_FROM_LF: assert property (@(posedge clk) disable iff (rst)
    aux_ce |-> $past(lf_tick)); // R3
endmodule

// File: tb/clk_en_ctrl_tb.sv
`timescale 1ns/1ps
module clk_en_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic lf_tick = 1'b0;
  logic cpu_off = 1'b0, scg0 = 1'b0, scg1 = 1'b0, osc_off = 1'b0;
  logic irq_req = 1'b0, wakeup_req = 1'b0;
  logic main_ce, sub_ce, aux_ce, fast_osc_en, lf_osc_en;
  logic n_main, n_sub, n_aux, n_fast, n_lf;

  int tests = 0;
  int fails = 0;
  int cm, cs, ca;
  int lf_ph = 0;
  localparam int LF_P = 3;
  localparam int WIN  = 192;

  always #4 clk = ~clk;

  clk_en_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .lf_tick(lf_tick), .cpu_off(cpu_off), .scg0(scg0), .scg1(scg1), .osc_off(osc_off),
    .irq_req(irq_req), .wakeup_req(wakeup_req), .main_ce(main_ce), .sub_ce(sub_ce),
    .aux_ce(aux_ce), .fast_osc_en(fast_osc_en), .lf_osc_en(lf_osc_en));

  clk_en_ctrl #(.ENABLE_SCG0(1'b0)) u_dut_noscg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .lf_tick(lf_tick), .cpu_off(cpu_off), .scg0(scg0), .scg1(scg1), .osc_off(osc_off),
    .irq_req(irq_req), .wakeup_req(wakeup_req), .main_ce(n_main), .sub_ce(n_sub),
    .aux_ce(n_aux), .fast_osc_en(n_fast), .lf_osc_en(n_lf));

  // low-frequency ticks: one every LF_P cycles, free running
  initial begin
    forever begin
      @(negedge clk);
      lf_ph   = (lf_ph == LF_P - 1) ? 0 : lf_ph + 1;
      lf_tick = (lf_ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic count(input int n);
    cm = 0; cs = 0; ca = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cm += int'(main_ce); cs += int'(sub_ce); ca += int'(aux_ce);
    end
  endtask

  // every gap between main pulses must be pa or pb; returns bad gaps and count of pb gaps
  task automatic gaps(input int n, input int pa, input int pb, output int bad, output int nb);
    int last;
    last = -1; bad = 0; nb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (main_ce) begin
        if (last >= 0) begin
          if ((i - last) != pa && (i - last) != pb) bad++;
          if ((i - last) == pb) nb++;
        end
        last = i;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad, nb;
    // R1 reset state
    cyc(3);
    chk("R1 main_ce in reset", int'(main_ce), 0);
    chk("R1 sub_ce in reset", int'(sub_ce), 0);
    chk("R1 aux_ce in reset", int'(aux_ce), 0);
    chk("R1 fast_osc_en in reset", int'(fast_osc_en), 1);
    chk("R1 lf_osc_en in reset", int'(lf_osc_en), 1);
    rst = 1'b0;
    cyc(10);
    count(WIN);
    chk("R1 default main /1 fast", cm, WIN);
    chk("R1 default sub /1 fast", cs, WIN);

    // R2 fast-source divider sweep for main and sub
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        wr(1'b1, 8'((m << 4) | (s << 1)));
        cyc(20);
        count(WIN);
        chk($sformatf("R2 main div code %0d", m), cm, WIN >> m);
        chk($sformatf("R2 sub div code %0d", s), cs, WIN >> s);
      end
    end
    // R2 R3 auxiliary divider sweep (low-frequency source)
    for (int a = 0; a < 4; a++) begin
      wr(1'b0, 8'(a << 4));
      cyc(40);
      count(WIN);
      chk($sformatf("R2 aux div code %0d", a), ca, (WIN / LF_P) >> a);
    end
    // R3 low-frequency source for main and sub
    for (int m = 0; m < 4; m++) begin
      wr(1'b1, 8'(8'h80 | (m << 4) | 8'h08 | (m << 1)));
      cyc(40);
      count(WIN);
      chk($sformatf("R3 main lf div code %0d", m), cm, (WIN / LF_P) >> m);
      chk($sformatf("R3 sub lf div code %0d", m), cs, (WIN / LF_P) >> m);
    end

    // R4 ratio change only at a pulse boundary
    wr(1'b1, 8'h30); cyc(23);
    wr(1'b1, 8'h10);
    gaps(60, 8, 2, bad, nb);
    chk("R4 /8 to /2 odd gaps", bad, 0);
    chk("R4 /8 to /2 new ratio reached", int'(nb > 0), 1);
    wr(1'b1, 8'h00); cyc(10);
    wr(1'b1, 8'h20);
    gaps(60, 1, 4, bad, nb);
    chk("R4 /1 to /4 odd gaps", bad, 0);
    chk("R4 /1 to /4 new ratio reached", int'(nb > 0), 1);

    // R11 reserved bits ignored
    wr(1'b1, 8'h41); wr(1'b0, 8'hCF);
    cyc(40);
    count(WIN);
    chk("R11 main unaffected", cm, WIN);
    chk("R11 sub unaffected", cs, WIN);
    chk("R11 aux unaffected", ca, WIN / LF_P);

    // R5 CPU off
    cpu_off = 1'b1;
    count(20);
    chk("R5 main stopped", cm, 0);
    chk("R7 sub still running", cs, 20);
    // R9 interrupt wakes main
    irq_req = 1'b1;
    @(negedge clk);
    chk("R9 main resumes on irq", int'(main_ce), 1);
    irq_req = 1'b0;
    @(negedge clk);
    chk("R5 main stops after irq drops", int'(main_ce), 0);

    // R6 fast oscillator off
    scg0 = 1'b1;
    @(negedge clk);
    chk("R6 fast_osc_en low", int'(fast_osc_en), 0);
    chk("R10 no-scg0 build keeps fast osc", int'(n_fast), 1);
    count(20);
    chk("R6 sub stopped with fast osc", cs, 0);
    chk("R6 main stopped", cm, 0);
    chk("R10 no-scg0 sub still runs", int'(n_sub), 1);
    wakeup_req = 1'b1;
    @(negedge clk);
    chk("R9 fast osc back after wakeup", int'(fast_osc_en), 1);
    chk("R9 main not yet pulsing", int'(main_ce), 0);
    @(negedge clk);
    chk("R9 main pulses one cycle later", int'(main_ce), 1);
    wakeup_req = 1'b0; scg0 = 1'b0; cpu_off = 1'b0;
    cyc(5);

    // R7 sub-main off
    scg1 = 1'b1;
    @(negedge clk);
    count(20);
    chk("R7 sub stopped", cs, 0);
    chk("R7 main unaffected", cm, 20);
    scg1 = 1'b0;

    // R8 low-frequency oscillator off
    osc_off = 1'b1;
    @(negedge clk);
    chk("R8 lf_osc_en low", int'(lf_osc_en), 0);
    count(30);
    chk("R8 aux stopped", ca, 0);
    wr(1'b1, 8'h80);
    count(30);
    chk("R8 lf-sourced main stopped", cm, 0);
    osc_off = 1'b0;
    cyc(10);
    count(30);
    chk("R8 lf-sourced main back", cm, 30 / LF_P);
    chk("R8 lf_osc_en back", int'(lf_osc_en), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule